// File: doc/BRIEF.md
# Host Bus to Register Bus Bridge

This block is a slave on an asynchronous, strobe-based microprocessor bus. It turns each host access into exactly one transfer on a synchronous internal register bus. The host qualifies an access with an active-low chip select, address strobe and data strobe. A read/write line is high for reads and low for writes. The address is 21 bits wide and the data path is 16 bits wide. The block passes the host's three strobes through a multi-flop synchronizer. It then raises an internal request and holds it until the register side signals completion. Completion may take anywhere from one clock to several dozen clocks, for example when another requester shares the target register.

The bridge signals completion on an active-low acknowledge output. This output has three states, and the pad's three-state driver is modelled as a value together with an output enable. The driver is off while chip select is high. It drives high once chip select is seen low, and goes low after the internal access has completed. It returns high as soon as the host releases either strobe. Read data is captured when completion arrives and is driven back through the data output enable. Write data is captured at the point of request and held steady for the whole internal access.

Top module: `hbus_bridge`

## Requirements
- R1: The internal request `reg_req` rises on the third rising clock edge after the inputs `host_cs_n`, `host_as_n` and `host_ds_n` have all become low. Two of those edges are spent in the two-flop synchronizer and one in the control register.
- R2: `reg_addr` always equals `host_addr`, with no clock delay.
- R3: `host_ack_oe` is 0 while the synchronized chip select is high. Once chip select has been seen low, `host_ack_oe` is 1 and `host_ack_n` is 1. `host_ack_n` stays 1 until an access completes.
- R4: `host_ack_n` goes to 0 only on the clock edge that follows a cycle with `reg_req` and `reg_done` both high. It stays 1 for however many cycles completion takes, including latencies of 32 clocks or more.
- R5: `reg_req` stays high until `reg_done` is sampled high. It is low in the cycle after that. Once the acknowledge is low, it returns to 1 after the release of either strobe alone has passed through the synchronizer.
- R6: Only one request is issued for each strobe assertion. While the strobes stay low after an acknowledge, no new request appears. A new request is possible only after both strobes have been seen high.
- R7: For a read (`host_rd_wr`=1), the data presented on `reg_rdata` in the completion cycle is latched and appears on `host_data_out`. `host_data_oe` is 1 only when chip select is seen low, `host_rd_wr` is 1 and read data has been captured. `host_data_oe` is 0 while a request is pending and 0 for writes.
- R8: For a write, `host_data_in` is latched on the edge where the request rises. It stays steady on `reg_wdata` until completion, and later changes of `host_data_in` have no effect on it.
- R9: `reg_wr` is 1 during a request if `host_rd_wr` was 0 on the edge where the request rose, and `reg_wr` is 0 whenever `reg_req` is 0.
- R10: While `rst_n` is low, `reg_req`, `reg_wr`, `host_ack_oe` and `host_data_oe` are 0, and `host_ack_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_as_n | input | 1 | Host address strobe, active low |
| host_ds_n | input | 1 | Host data strobe, active low |
| host_rd_wr | input | 1 | 1 = read, 0 = write |
| host_addr | input | ADDR_W | Host address |
| host_data_in | input | DATA_W | Write data from the host data pads |
| host_data_out | output | DATA_W | Read data to the host data pads |
| host_data_oe | output | 1 | Output enable of the data pads |
| host_ack_n | output | 1 | Acknowledge value, active low |
| host_ack_oe | output | 1 | Output enable of the acknowledge pad |
| reg_req | output | 1 | Internal access request |
| reg_wr | output | 1 | Internal write enable |
| reg_addr | output | ADDR_W | Internal address |
| reg_wdata | output | DATA_W | Internal write data |
| reg_rdata | input | DATA_W | Internal read data |
| reg_done | input | 1 | Internal completion pulse |

## Verification
On every cycle, the assertions check the following:
- the acknowledge leaves three-state at its inactive level;
- the acknowledge falls only after a completion;
- the acknowledge rises again once a strobe is released;
- the request is held until completion and then dropped;
- write data stays still while a write request is pending;
- the data pads are never driven while a request is outstanding.

Some behaviours need the bench's scenarios. These are the exact three-edge launch latency, one request per strobe assertion while the strobes stay low, the captured read value, and holding off the acknowledge across latencies from 1 to 40 clocks.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_ACK  = 2'd2,
      ST_REL  = 2'd3
   } hbus_state_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[0] <= RST_VAL;
      else        st[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[i] <= RST_VAL;
         else        st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
   import hbus_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s_n,
   input  logic as_s_n,
   input  logic ds_s_n,
   input  logic done,
   output logic req,
   output logic launch,
   output logic ack_act
);
   hbus_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      launch  = 1'b0;
      unique case (state_q)
         ST_IDLE: if (!cs_s_n && !as_s_n && !ds_s_n) begin
            state_d = ST_REQ;
            launch  = 1'b1;
         end
         ST_REQ:  if (done) state_d = ST_ACK;
         ST_ACK:  if (as_s_n || ds_s_n) state_d = ST_REL;
         ST_REL:  if (as_s_n && ds_s_n) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign req     = (state_q == ST_REQ);
   assign ack_act = (state_q == ST_ACK);
endmodule

// File: rtl/hbus_dpath.sv
module hbus_dpath #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              done,
   input  logic              req,
   input  logic              cs_s_n,
   input  logic              host_rd_wr,
   input  logic [DATA_W-1:0] host_data_in,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              rw_q,
   output logic              rd_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_q  <= '0;
         rdata_q  <= '0;
         rw_q     <= 1'b1;
         rd_valid <= 1'b0;
      end else begin
         if (launch) begin
            wdata_q  <= host_data_in;
            rw_q     <= host_rd_wr;
            rd_valid <= 1'b0;
         end else if (req && done && rw_q) begin
            rdata_q  <= reg_rdata;
            rd_valid <= 1'b1;
         end else if (cs_s_n) begin
            rd_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/hbus_bridge.sv
module hbus_bridge #(
   parameter int ADDR_W      = 21,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs_n,
   input  logic              host_as_n,
   input  logic              host_ds_n,
   input  logic              host_rd_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_data_in,
   output logic [DATA_W-1:0] host_data_out,
   output logic              host_data_oe,
   output logic              host_ack_n,
   output logic              host_ack_oe,
   output logic              reg_req,
   output logic              reg_wr,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic              reg_done
);
   localparam int NSTROBE = 3;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hbus_bridge: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("hbus_bridge: widths must be positive");
   end

   logic [NSTROBE-1:0] strb_s;
   logic cs_s_n, as_s_n, ds_s_n;
   logic launch, ack_act, rw_q, rd_valid;
   logic [DATA_W-1:0] rdata_q;

   hbus_sync #(.W(NSTROBE), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({host_cs_n, host_as_n, host_ds_n}),
      .q     (strb_s)
   );
   assign {cs_s_n, as_s_n, ds_s_n} = strb_s;

   hbus_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_s_n  (cs_s_n),
      .as_s_n  (as_s_n),
      .ds_s_n  (ds_s_n),
      .done    (reg_done),
      .req     (reg_req),
      .launch  (launch),
      .ack_act (ack_act)
   );

   hbus_dpath #(.DATA_W(DATA_W)) u_dpath (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch       (launch),
      .done         (reg_done),
      .req          (reg_req),
      .cs_s_n       (cs_s_n),
      .host_rd_wr   (host_rd_wr),
      .host_data_in (host_data_in),
      .reg_rdata    (reg_rdata),
      .wdata_q      (reg_wdata),
      .rdata_q      (rdata_q),
      .rw_q         (rw_q),
      .rd_valid     (rd_valid)
   );

   assign reg_addr      = host_addr;
   assign reg_wr        = reg_req & ~rw_q;
   assign host_ack_oe   = ~cs_s_n;
   assign host_ack_n    = ~ack_act;
   assign host_data_out = rdata_q;
   assign host_data_oe  = ~cs_s_n & host_rd_wr & rd_valid;
endmodule

// File: rtl/hbus_bridge_chk.sv
module hbus_bridge_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              as_s_n,
   input logic              ds_s_n,
   input logic              host_ack_n,
   input logic              host_ack_oe,
   input logic              host_data_oe,
   input logic              reg_req,
   input logic              reg_wr,
   input logic              reg_done,
   input logic [DATA_W-1:0] reg_wdata
);
   AST_ACK_LEAVES_TRI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_ack_oe) |-> host_ack_n) else $error("ack left three-state low"); // R3

   AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_ack_n) |-> $past(reg_done && reg_req)) else $error("ack without completion"); // R4

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_done) |=> reg_req) else $error("request dropped early"); // R5

   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_done) |=> !reg_req) else $error("request not dropped"); // R5

   AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_ack_n && (as_s_n || ds_s_n)) |=> host_ack_n) else $error("ack not released"); // R5

   AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && reg_wr && !reg_done) |=> $stable(reg_wdata)) else $error("write data moved"); // R8

   AST_NO_DRIVE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req |-> !host_data_oe) else $error("data pads driven during request"); // R7
endmodule

bind hbus_bridge hbus_bridge_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/hbus_bridge_test.sv
module hbus_bridge_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 21;
   localparam int DW = 16;

   typedef struct packed {
      logic          rw;
      logic          rel_as;
      logic [6:0]    lat;
      logic [AW-1:0] addr;
      logic [DW-1:0] wd;
      logic [DW-1:0] rd;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 1'b0, 7'd1,  21'h000010, 16'h0000, 16'hA5C3},
      '{1'b0, 1'b1, 7'd1,  21'h1FFFFF, 16'h1234, 16'h0000},
      '{1'b1, 1'b1, 7'd5,  21'h0ABCDE, 16'h0000, 16'h5A5A},
      '{1'b0, 1'b0, 7'd7,  21'h155555, 16'hFFFF, 16'h0000},
      '{1'b1, 1'b0, 7'd32, 21'h100000, 16'h0000, 16'hBEEF},
      '{1'b0, 1'b1, 7'd40, 21'h000001, 16'h8001, 16'h0000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_cs_n = 1'b1, host_as_n = 1'b1, host_ds_n = 1'b1, host_rd_wr = 1'b1;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_data_in = '0;
   logic [DW-1:0] host_data_out, reg_wdata;
   logic [DW-1:0] reg_rdata = '0;
   logic [AW-1:0] reg_addr;
   logic host_data_oe, host_ack_n, host_ack_oe, reg_req, reg_wr;
   logic reg_done = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [6:0]    rsp_lat = 7'd1;
   logic [DW-1:0] rsp_data = '0;
   int            rsp_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hbus_bridge uut (
      .clk(clk), .rst_n(rst_n),
      .host_cs_n(host_cs_n), .host_as_n(host_as_n), .host_ds_n(host_ds_n),
      .host_rd_wr(host_rd_wr), .host_addr(host_addr), .host_data_in(host_data_in),
      .host_data_out(host_data_out), .host_data_oe(host_data_oe),
      .host_ack_n(host_ack_n), .host_ack_oe(host_ack_oe),
      .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_done(reg_done)
   );

   // register-side model with programmable latency
   always @(posedge clk) begin
      if (reg_req && !reg_done) begin
         if (rsp_cnt == int'(rsp_lat) - 1) begin
            reg_done  <= 1'b1;
            reg_rdata <= rsp_data;
            rsp_cnt   <= 0;
         end else begin
            rsp_cnt <= rsp_cnt + 1;
         end
      end else begin
         reg_done <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic txn(input vec_t v);
      int req_cycles = 0;
      int guard = 0;
      rsp_lat  = v.lat;
      rsp_data = v.rd;
      @(negedge clk);
      host_addr = v.addr; host_rd_wr = v.rw; host_data_in = v.wd; host_cs_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(host_ack_oe == 1'b1 && host_ack_n == 1'b1, "R3", {host_ack_oe, host_ack_n}, 2'b11);
      chk(reg_addr == v.addr, "R2", reg_addr, v.addr);
      host_as_n = 1'b0; host_ds_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(reg_req == 1'b0, "R1", reg_req, 0);
      @(negedge clk);
      chk(reg_req == 1'b1, "R1", reg_req, 1);
      chk(reg_wr == !v.rw, "R9", reg_wr, !v.rw);
      chk(host_data_oe == 1'b0, "R7", host_data_oe, 0);
      if (!v.rw) begin
         chk(reg_wdata == v.wd, "R8", reg_wdata, v.wd);
         host_data_in = ~v.wd;
      end
      while (reg_req && guard < 200) begin
         req_cycles++;
         guard++;
         if (host_ack_n !== 1'b1) chk(1'b0, "R4", host_ack_n, 1);
         if (!v.rw && reg_wdata !== v.wd) chk(1'b0, "R8", reg_wdata, v.wd);
         @(negedge clk);
      end
      chk(req_cycles == int'(v.lat) + 1, "R5", req_cycles, int'(v.lat) + 1);
      chk(host_ack_n == 1'b0, "R4", host_ack_n, 0);
      chk(host_data_oe == v.rw, "R7", host_data_oe, v.rw);
      if (v.rw) chk(host_data_out == v.rd, "R7", host_data_out, v.rd);
      // strobes held low: no second request, ack stays active
      begin
         bit extra = 1'b0;
         for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (reg_req) extra = 1'b1;
         end
         chk(!extra && host_ack_n == 1'b0, "R6", {extra, host_ack_n}, 2'b00);
      end
      if (v.rel_as) host_as_n = 1'b1; else host_ds_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(host_ack_n == 1'b0, "R5", host_ack_n, 0);
      @(negedge clk);
      chk(host_ack_n == 1'b1, "R5", host_ack_n, 1);
      // one strobe still low: no new request may start
      repeat (4) @(negedge clk);
      chk(reg_req == 1'b0, "R6", reg_req, 0);
      host_as_n = 1'b1; host_ds_n = 1'b1; host_cs_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(host_ack_oe == 1'b0 && host_data_oe == 1'b0, "R3", {host_ack_oe, host_data_oe}, 2'b00);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(reg_req == 0 && reg_wr == 0 && host_ack_oe == 0 && host_data_oe == 0 && host_ack_n == 1,
          "R10", {reg_req, reg_wr, host_ack_oe, host_data_oe, host_ack_n}, 5'b00001);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int k = 0; k < NVEC; k++) txn(VEC[k]);

      // directed: address passes through combinationally at any time
      host_addr = 21'h0F0F0F;
      #1;
      chk(reg_addr == 21'h0F0F0F, "R2", reg_addr, 21'h0F0F0F);

      // directed: strobes low while chip select high never starts a request
      @(negedge clk);
      host_as_n = 1'b0; host_ds_n = 1'b0;
      repeat (6) @(negedge clk);
      chk(reg_req == 1'b0 && host_ack_oe == 1'b0, "R1", {reg_req, host_ack_oe}, 2'b00);
      host_as_n = 1'b1; host_ds_n = 1'b1;
      repeat (3) @(negedge clk);

      // directed: back-to-back transfers after full release
      txn('{1'b0, 1'b0, 7'd2, 21'h0000AA, 16'h00FF, 16'h0000});
      txn('{1'b1, 1'b1, 7'd3, 21'h0000AB, 16'h0000, 16'hC0DE});

      // directed: reset in the middle of a pending request
      rsp_lat = 7'd60;
      host_rd_wr = 1'b1; host_cs_n = 1'b0; host_as_n = 1'b0; host_ds_n = 1'b0;
      repeat (6) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(reg_req == 0 && host_ack_oe == 0 && host_ack_n == 1, "R10",
          {reg_req, host_ack_oe, host_ack_n}, 3'b001);
      host_cs_n = 1'b1; host_as_n = 1'b1; host_ds_n = 1'b1;

      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         chk(1'b0, "watchdog", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule